// File: doc/BRIEF.md
# Dual Data Pointer with Auto-Step and Select Toggle

This block holds two 16-bit data pointers for an 8051-style core and presents the currently active one on a registered output. A select bit in a small control register picks the active pointer. Software loads either pointer byte by byte, or it rewrites the control byte, through a single-cycle register write port.

The instruction decoder drives three single-cycle pulses. The first marks a completed pointer access. The second loads a 16-bit immediate into the active pointer. The third adds one to the active pointer. When automatic stepping is enabled, each access pulse moves the active pointer up or down by one. Each pointer has its own direction bit. When toggle mode is enabled, every pulsed pointer operation inverts the select bit once the pointer itself has been updated. Software can then alternate between a source pointer and a destination pointer without issuing select writes.

Top module: `dual_dptr_unit`

## Requirements
- R1: After a synchronous reset both pointers are 0000h and all control bits are 0, so `ptr_out` is 0000h and `sel_out` is 0. In this state an access pulse changes nothing.
- R2: A write at address 0 sets the low byte of pointer 0 and a write at address 1 sets its high byte. Addresses 2 and 3 set the low and high bytes of pointer 1. Address 4 is the control byte: bit 0 is select, bit 1 is toggle enable, bit 2 is auto-step enable, bit 3 is the direction of pointer 0 and bit 4 is the direction of pointer 1, where direction 1 means decrement. Bits 7:5 are discarded.
- R3: `ptr_out` shows pointer 1 when the select bit is 1 and pointer 0 when it is 0, and `sel_out` shows the select bit.
- R4: A load pulse writes `load_val` into the active pointer.
- R5: An increment pulse adds one to the active pointer whatever its direction bit is, and FFFFh wraps to 0000h.
- R6: An access pulse with auto-step enabled moves the active pointer by +1 when its direction bit is 0 and by -1 when it is 1. FFFFh wraps to 0000h and 0000h wraps to FFFFh. With auto-step disabled, an access pulse leaves the pointer unchanged.
- R7: With toggle enabled, any access, load or increment pulse inverts the select bit. The pointer that is modified is the one selected before the toggle. With toggle disabled the select bit holds.
- R8: A pulse never changes the inactive pointer.
- R9: In a cycle in which `wr_en` is high, all three pulses are ignored. Only the register write takes effect.
- R10: When several pulses arrive together, load takes priority over increment, and increment takes priority over access. The select bit toggles at most once.
- R11: `ptr_out` and `sel_out` are registered. A write or pulse sampled at a clock edge appears on them right after that edge, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0..3 pointer bytes, 4 control) |
| wr_data | input | 8 | Register write data |
| ptr_use | input | 1 | Pulse: pointer access completed |
| ptr_load | input | 1 | Pulse: load `load_val` into the active pointer |
| ptr_inc | input | 1 | Pulse: increment the active pointer |
| load_val | input | 16 | Immediate value for a load |
| ptr_out | output | 16 | Active pointer, registered |
| sel_out | output | 1 | Current select bit, registered |

## Verification
The bench sweeps all 32 control byte values and applies each of the three pulse kinds against pointer values at the arithmetic edges: 0000h, 0001h, 7FFFh, 8000h, FFFEh and FFFFh. This separates increment from decrement, exposes wrap errors in both directions, and shows whether a change in direction bits or in the enable bits is picked up. After every operation the select bit is rewritten to the opposite value, so that the bench can read the other pointer at the output. This reveals an update to the wrong pointer, or an update performed after the toggle. Separate cases cover simultaneous pulses, pulses during a register write, and the registered output timing.

// File: rtl/dptr_pkg.sv
package dptr_pkg;
  // control byte layout: bit0 sel, bit1 toggle, bit2 auto-step, bit3 dir ptr0, bit4 dir ptr1
  typedef struct packed {
    logic dir1;
    logic dir0;
    logic auto_en;
    logic tog_en;
    logic sel;
  } dptr_ctrl_t;

  localparam int CTRL_BITS = $bits(dptr_ctrl_t);
  localparam int NUM_PTR   = 2;
endpackage

// File: rtl/dptr_op_dec.sv
module dptr_op_dec (
  input  logic wr_en,
  input  logic ptr_use,
  input  logic ptr_load,
  input  logic ptr_inc,
  output logic do_load,
  output logic do_inc,
  output logic do_use,
  output logic any_op
);
  // register writes suppress every pulse; load > inc > use
  always_comb begin
    do_load = !wr_en && ptr_load;
    do_inc  = !wr_en && !ptr_load && ptr_inc;
    do_use  = !wr_en && !ptr_load && !ptr_inc && ptr_use;
    any_op  = do_load || do_inc || do_use;
  end
endmodule

// File: rtl/dptr_ctrl.sv
module dptr_ctrl
  import dptr_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int BYTE_W    = 8,
  parameter int CTRL_ADDR = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              any_op,
  output dptr_ctrl_t        ctrl_q,
  output logic              sel_d
);
  dptr_ctrl_t ctrl_d;
  logic       ctrl_hit;
  logic       unused_ctrl_bits;

  assign ctrl_hit         = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR));
  assign unused_ctrl_bits = ^wr_data[BYTE_W-1:CTRL_BITS];

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_hit) begin
      ctrl_d = dptr_ctrl_t'(wr_data[CTRL_BITS-1:0]);
    end else if (any_op && ctrl_q.tog_en) begin
      ctrl_d.sel = ~ctrl_q.sel;
    end
  end

  assign sel_d = ctrl_d.sel;

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else     ctrl_q <= ctrl_d;
  end

  // R7
  sel_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (any_op && ctrl_q.tog_en) |=> (ctrl_q.sel != $past(ctrl_q.sel)));

  // R7
  sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_hit && !(any_op && ctrl_q.tog_en)) |=> $stable(ctrl_q));

  // R9
  wr_no_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !ctrl_hit) |=> $stable(ctrl_q));
endmodule

// File: rtl/dptr_reg.sv
module dptr_reg #(
  parameter int PTR_W  = 16,
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 3,
  parameter int IDX    = 0,
  localparam int NBYTES = PTR_W / BYTE_W,
  localparam int BASE   = IDX * NBYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              active,
  input  logic              do_load,
  input  logic              do_inc,
  input  logic              do_use,
  input  logic              auto_en,
  input  logic              dir_dec,
  input  logic [PTR_W-1:0]  load_val,
  output logic [PTR_W-1:0]  ptr_q,
  output logic [PTR_W-1:0]  ptr_d
);
  logic [PTR_W-1:0] step_val;
  logic             step_en;

  assign step_en  = active && do_use && auto_en;
  assign step_val = dir_dec ? (ptr_q - PTR_W'(1)) : (ptr_q + PTR_W'(1));

  always_comb begin
    ptr_d = ptr_q;
    if (wr_en) begin
      for (int b = 0; b < NBYTES; b++) begin
        if (wr_addr == ADDR_W'(BASE + b)) ptr_d[b*BYTE_W +: BYTE_W] = wr_data;
      end
    end else if (active) begin
      if (do_load)      ptr_d = load_val;
      else if (do_inc)  ptr_d = ptr_q + PTR_W'(1);
      else if (step_en) ptr_d = step_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ptr_q <= '0;
    else     ptr_q <= ptr_d;
  end

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!active && !wr_en) |=> $stable(ptr_q));

  // R5
  inc_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (active && do_inc && (ptr_q == '1)) |=> (ptr_q == '0));

  // R6
  dec_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (active && do_use && auto_en && dir_dec && (ptr_q == '0)) |=> (ptr_q == '1));

  // R4
  load_take_chk: assert property (@(posedge clk) disable iff (rst)
    (active && do_load) |=> (ptr_q == $past(load_val)));
endmodule

// File: rtl/dual_dptr_unit.sv
module dual_dptr_unit
  import dptr_pkg::*;
#(
  parameter int PTR_W  = 16,
  parameter int BYTE_W = 8,
  localparam int NBYTES    = PTR_W / BYTE_W,
  localparam int CTRL_ADDR = NUM_PTR * NBYTES,
  localparam int ADDR_W    = $clog2(CTRL_ADDR + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              ptr_use,
  input  logic              ptr_load,
  input  logic              ptr_inc,
  input  logic [PTR_W-1:0]  load_val,
  output logic [PTR_W-1:0]  ptr_out,
  output logic              sel_out
);
  logic             do_load, do_inc, do_use, any_op;
  dptr_ctrl_t       ctrl_q;
  logic             sel_d;
  logic [PTR_W-1:0] ptr_q [NUM_PTR];
  logic [PTR_W-1:0] ptr_d [NUM_PTR];
  logic [PTR_W-1:0] out_q;

  dptr_op_dec u_dec (
    .wr_en    (wr_en),
    .ptr_use  (ptr_use),
    .ptr_load (ptr_load),
    .ptr_inc  (ptr_inc),
    .do_load  (do_load),
    .do_inc   (do_inc),
    .do_use   (do_use),
    .any_op   (any_op)
  );

  dptr_ctrl #(
    .ADDR_W    (ADDR_W),
    .BYTE_W    (BYTE_W),
    .CTRL_ADDR (CTRL_ADDR)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .any_op  (any_op),
    .ctrl_q  (ctrl_q),
    .sel_d   (sel_d)
  );

  for (genvar p = 0; p < NUM_PTR; p++) begin : g_ptr
    logic active;
    logic dir_dec;
    assign active  = (ctrl_q.sel == p[0]);
    assign dir_dec = (p == 0) ? ctrl_q.dir0 : ctrl_q.dir1;

    dptr_reg #(
      .PTR_W  (PTR_W),
      .BYTE_W (BYTE_W),
      .ADDR_W (ADDR_W),
      .IDX    (p)
    ) u_reg (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .active   (active),
      .do_load  (do_load),
      .do_inc   (do_inc),
      .do_use   (do_use),
      .auto_en  (ctrl_q.auto_en),
      .dir_dec  (dir_dec),
      .load_val (load_val),
      .ptr_q    (ptr_q[p]),
      .ptr_d    (ptr_d[p])
    );
  end

  // output register tracks the pointer that will be active after this edge
  always_ff @(posedge clk) begin
    if (rst) out_q <= '0;
    else     out_q <= sel_d ? ptr_d[1] : ptr_d[0];
  end

  assign ptr_out = out_q;
  assign sel_out = ctrl_q.sel;

  // R3
  out_match_chk: assert property (@(posedge clk) disable iff (rst)
    ptr_out == (sel_out ? ptr_q[1] : ptr_q[0]));

  // R10
  single_op_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({do_load, do_inc, do_use}));
endmodule

// File: tb/dual_dptr_unit_tb_top.sv
module dual_dptr_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [7:0]  wr_data;
  logic        ptr_use, ptr_load, ptr_inc;
  logic [15:0] load_val;
  logic [15:0] ptr_out;
  logic        sel_out;

  int checks = 0;
  int failures = 0;

  // bench model
  logic [15:0] mp [2];
  logic        msel, mtog, mauto, mdir0, mdir1;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_dptr_unit dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ptr_use(ptr_use), .ptr_load(ptr_load), .ptr_inc(ptr_inc), .load_val(load_val),
    .ptr_out(ptr_out), .sel_out(sel_out)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] edge_val(int k);
    case (k)
      0: return 16'h0000;
      1: return 16'h0001;
      2: return 16'hFFFF;
      3: return 16'hFFFE;
      4: return 16'h8000;
      default: return 16'h7FFF;
    endcase
  endfunction

  // one cycle of stimulus: drive at negedge, model update, sample at next negedge
  task automatic step(logic w, logic [2:0] a, logic [7:0] d,
                      logic u, logic l, logic i, logic [15:0] lv);
    wr_en = w; wr_addr = a; wr_data = d;
    ptr_use = u; ptr_load = l; ptr_inc = i; load_val = lv;
    if (w) begin
      case (a)
        3'd0: mp[0][7:0]  = d;
        3'd1: mp[0][15:8] = d;
        3'd2: mp[1][7:0]  = d;
        3'd3: mp[1][15:8] = d;
        3'd4: begin
          msel = d[0]; mtog = d[1]; mauto = d[2]; mdir0 = d[3]; mdir1 = d[4];
        end
        default: ;
      endcase
    end else if (u || l || i) begin
      if (l)          mp[msel] = lv;
      else if (i)     mp[msel] = mp[msel] + 16'd1;
      else if (mauto) mp[msel] = ((msel ? mdir1 : mdir0)) ? mp[msel] - 16'd1 : mp[msel] + 16'd1;
      if (mtog) msel = ~msel;
    end
    @(posedge clk);
    @(negedge clk);
    wr_en = 0; ptr_use = 0; ptr_load = 0; ptr_inc = 0;
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    step(1'b1, a, d, 1'b0, 1'b0, 1'b0, 16'h0);
  endtask

  function automatic logic [7:0] ctrl_byte(logic s);
    return {3'b000, mdir1, mdir0, mauto, mtog, s};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired (R11 timing) actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wr_en = 0; wr_addr = 0; wr_data = 0; ptr_use = 0; ptr_load = 0; ptr_inc = 0; load_val = 0;
    mp[0] = 0; mp[1] = 0; msel = 0; mtog = 0; mauto = 0; mdir0 = 0; mdir1 = 0;
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;

    // R1 reset state and inert access pulse
    chk("R1 ptr after reset", ptr_out, 16'h0000);
    chk("R1 sel after reset", {15'd0, sel_out}, 16'd0);
    step(1'b0, 3'd0, 8'd0, 1'b1, 1'b0, 1'b0, 16'h0);
    chk("R1 access with reset controls", ptr_out, 16'h0000);
    chk("R1 sel unchanged", {15'd0, sel_out}, 16'd0);

    // main sweep: every control byte, every pulse kind, edge values
    for (int c = 0; c < 32; c++) begin
      for (int op = 0; op < 3; op++) begin
        for (int k = 0; k < 6; k++) begin
          logic [15:0] v0, v1, lv;
          v0 = edge_val(k);
          v1 = edge_val((k + 2) % 6) ^ 16'h0F0F;
          lv = 16'hA55A ^ 16'(c * 97 + k);
          wr(3'd0, v0[7:0]); wr(3'd1, v0[15:8]);
          wr(3'd2, v1[7:0]); wr(3'd3, v1[15:8]);
          wr(3'd4, 8'(c) | 8'hE0);
          chk("R2 R3 active after setup", ptr_out, mp[msel]);
          chk("R2 sel after setup", {15'd0, sel_out}, {15'd0, msel});
          case (op)
            0: begin
              step(1'b0, 3'd0, 8'd0, 1'b0, 1'b1, 1'b0, lv);
              chk("R4 load into active", ptr_out, mp[msel]);
            end
            1: begin
              step(1'b0, 3'd0, 8'd0, 1'b0, 1'b0, 1'b1, lv);
              chk("R5 increment active", ptr_out, mp[msel]);
            end
            default: begin
              step(1'b0, 3'd0, 8'd0, 1'b1, 1'b0, 1'b0, lv);
              chk("R6 access auto-step", ptr_out, mp[msel]);
            end
          endcase
          chk("R7 sel after pulse", {15'd0, sel_out}, {15'd0, msel});
          wr(3'd4, ctrl_byte(~msel));
          chk("R8 R7 other pointer", ptr_out, mp[msel]);
        end
      end
    end

    // R9 pulses during a register write are ignored
    wr(3'd0, 8'h34); wr(3'd1, 8'h12); wr(3'd2, 8'h78); wr(3'd3, 8'h56);
    wr(3'd4, 8'h06); // toggle + auto, sel 0, increment
    step(1'b1, 3'd2, 8'hAA, 1'b1, 1'b1, 1'b1, 16'hDEAD);
    chk("R9 sel held during write", {15'd0, sel_out}, 16'd0);
    chk("R9 active pointer untouched", ptr_out, 16'h1234);
    wr(3'd4, 8'h07);
    chk("R9 written byte only", ptr_out, 16'h56AA);

    // R10 simultaneous pulses: load wins, one toggle
    wr(3'd4, 8'h06);
    step(1'b0, 3'd0, 8'd0, 1'b1, 1'b1, 1'b1, 16'hBEEF);
    chk("R10 sel toggled once", {15'd0, sel_out}, 16'd1);
    chk("R10 other pointer shown", ptr_out, 16'h56AA);
    wr(3'd4, 8'h06);
    chk("R10 load won", ptr_out, 16'hBEEF);
    step(1'b0, 3'd0, 8'd0, 1'b1, 1'b0, 1'b1, 16'h0);
    wr(3'd4, 8'h00);
    chk("R10 inc over access", ptr_out, 16'hBEF0);

    // R11 output changes only after the edge
    wr(3'd4, 8'h00);
    wr_en = 0; ptr_load = 1; load_val = 16'h4321;
    #(CLK_PERIOD/4);
    chk("R11 no change before edge", ptr_out, 16'hBEF0);
    @(posedge clk);
    #1;
    ptr_load = 0;
    chk("R11 change right after edge", ptr_out, 16'h4321);
    @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule